// File: doc/BRIEF.md
# Indexed Configuration Register File

This block is a small bank of byte-wide configuration registers that a host reaches through two adjacent I/O port addresses. The host first writes a register number to the lower (index) port, then reads or writes the chosen register through the upper (data) port. The block holds these registers:

- a fixed identification byte;
- a fixed revision byte;
- a function-select byte that switches peripherals on and picks a parallel-port mode;
- four base-address bytes.

Their decoded contents go straight to the rest of the chip as enables, a mode field and 10-bit I/O base addresses.

An external configuration-mode input gates all register access. While it is low, the host cannot touch the bank. In that state the data port address returns a read-only status byte supplied from outside the block. Bits that are reserved or that must be zero are cleared in hardware whenever a register is written, so they always read back as zero.

The host side is a single-cycle strobe interface with no back-pressure: every read or write strobe is taken in the cycle it is presented, so no valid/ready handshake is needed. Read data is registered. It appears one clock after the read strobe and holds until the next read strobe.

Top module: `cfg_regbank`

## Requirements
- R1: A synchronous active-high reset clears the following to 00h: the index latch, the read data register and all four base-address registers. It also sets function select to 03h, so all three peripheral enables are 0 and the parallel mode is 11 (disabled).
- R2: With configuration mode high, a write at 3F0h loads the 8-bit index. A read at 3F0h returns that index on `io_rdata` one cycle after the read strobe.
- R3: With configuration mode low, writes to 3F0h and 3F1h change neither the index nor any register. A read at 3F1h returns `ext_status`, and a read at 3F0h returns 00h.
- R4: Index E0h reads 3Ch and index E1h reads 00h, and writes to either index are ignored.
- R5: Index E2h is function select, with a write mask of 1Fh. Bit 4 drives `fdc_en`, bit 3 drives `sp2_en` and bit 2 drives `sp1_en`. Bits 1:0 drive `par_mode`, where 00 = unidirectional, 01 = extended-capability, 10 = enhanced and 11 = disabled. Bits 7:5 always read as 0.
- R6: Index E3h has bits 1:0 forced to 0. `fdc_base` equals the register value shifted left by two.
- R7: Index E6h stores all 8 bits. `par_base` equals the register value shifted left by two.
- R8: Indexes E7h and E8h have bit 0 forced to 0. `sp1_base` and `sp2_base` equal the respective register value shifted left by two.
- R9: Indexes other than E0h–E3h and E6h–E8h read 00h, and writes to them leave every register unchanged.
- R10: The index keeps its value across changes of configuration mode.
- R11: A read and a write strobe together at 3F1h return the register's value from before the write, and the write still takes effect. `io_rdata` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode_en | input | 1 | Configuration-mode enable; gates all access |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| ext_status | input | 8 | External read-only status byte, shown at 3F1h when not in configuration mode |
| fdc_en | output | 1 | Floppy controller enable |
| sp1_en | output | 1 | Serial port 1 enable |
| sp2_en | output | 1 | Serial port 2 enable |
| par_mode | output | 2 | Parallel port mode |
| fdc_base | output | 10 | Floppy controller I/O base |
| par_base | output | 10 | Parallel port I/O base |
| sp1_base | output | 10 | Serial port 1 I/O base |
| sp2_base | output | 10 | Serial port 2 I/O base |

## Verification
A read and a write of the same data-port register can land in the same clock. The bench provokes this by raising both strobes together at 3F1h. It expects the read to return the value from before the write, and a following plain read to return the newly written value.

A second collision is a write arriving in the very cycle that configuration mode drops. The bench judges it by reading back the index and the register once the mode is raised again: both must be unchanged.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

  localparam int DW       = 8;
  localparam int NUM_BASE = 4;
  localparam int BASE_W   = 10;

  typedef enum logic [1:0] {
    PAR_UNI = 2'b00,
    PAR_ECP = 2'b01,
    PAR_EPP = 2'b10,
    PAR_OFF = 2'b11
  } par_mode_e;

  localparam logic [DW-1:0] IDX_ID   = 8'hE0;
  localparam logic [DW-1:0] IDX_REV  = 8'hE1;
  localparam logic [DW-1:0] IDX_FN   = 8'hE2;
  localparam logic [DW-1:0] FN_WMASK = 8'h1F;

  // slot order: 0 floppy, 1 parallel, 2 serial 1, 3 serial 2
  function automatic logic [DW-1:0] base_idx(input int slot);
    case (slot)
      0:       return 8'hE3;
      1:       return 8'hE6;
      2:       return 8'hE7;
      default: return 8'hE8;
    endcase
  endfunction

  function automatic logic [DW-1:0] base_mask(input int slot);
    case (slot)
      0:       return 8'hFC;
      1:       return 8'hFF;
      default: return 8'hFE;
    endcase
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_mode_en,
  input  logic [ADDR_W-1:0]               io_addr,
  input  logic                            io_wr,
  input  logic [cfg_regbank_pkg::DW-1:0]  io_wdata,
  output logic                            hit_idx,
  output logic                            hit_data,
  output logic                            data_wr,
  output logic [cfg_regbank_pkg::DW-1:0]  idx_q
);
  import cfg_regbank_pkg::*;

  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(INDEX_PORT + 1);

  assign hit_idx  = (io_addr == INDEX_PORT);
  assign hit_data = (io_addr == DATA_PORT);

  // Only configuration mode lets a write reach either port.
  logic idx_wr;
  assign idx_wr  = cfg_mode_en && io_wr && hit_idx;
  assign data_wr = cfg_mode_en && io_wr && hit_data;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= io_wdata;
  end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store #(
  parameter logic [7:0] FN_RESET = 8'h03
) (
  input  logic                                                  clk,
  input  logic                                                  rst,
  input  logic                                                  data_wr,
  input  logic [cfg_regbank_pkg::DW-1:0]                        idx,
  input  logic [cfg_regbank_pkg::DW-1:0]                        wdata,
  output logic [cfg_regbank_pkg::DW-1:0]                        fn_q,
  output logic [cfg_regbank_pkg::NUM_BASE-1:0][cfg_regbank_pkg::DW-1:0] base_q
);
  import cfg_regbank_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)
      fn_q <= FN_RESET & FN_WMASK;
    else if (data_wr && idx == IDX_FN)
      fn_q <= wdata & FN_WMASK;
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    localparam logic [DW-1:0] MY_IDX  = base_idx(g);
    localparam logic [DW-1:0] MY_MASK = base_mask(g);
    always_ff @(posedge clk) begin
      if (rst)
        base_q[g] <= '0;
      else if (data_wr && idx == MY_IDX)
        base_q[g] <= wdata & MY_MASK;
    end
  end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
  parameter logic [7:0] DEV_ID  = 8'h3C,
  parameter logic [7:0] DEV_REV = 8'h00
) (
  input  logic                                                  clk,
  input  logic                                                  rst,
  input  logic                                                  io_rd,
  input  logic                                                  cfg_mode_en,
  input  logic                                                  hit_idx,
  input  logic                                                  hit_data,
  input  logic [cfg_regbank_pkg::DW-1:0]                        idx,
  input  logic [cfg_regbank_pkg::DW-1:0]                        fn_q,
  input  logic [cfg_regbank_pkg::NUM_BASE-1:0][cfg_regbank_pkg::DW-1:0] base_q,
  input  logic [cfg_regbank_pkg::DW-1:0]                        ext_status,
  output logic [cfg_regbank_pkg::DW-1:0]                        io_rdata
);
  import cfg_regbank_pkg::*;

  logic [DW-1:0] reg_sel;
  logic [DW-1:0] rd_next;

  // Register selected by the index; unlisted indexes give zero.
  always_comb begin
    reg_sel = '0;
    case (idx)
      IDX_ID:  reg_sel = DEV_ID;
      IDX_REV: reg_sel = DEV_REV;
      IDX_FN:  reg_sel = fn_q;
      default: begin
        for (int i = 0; i < NUM_BASE; i++)
          if (idx == base_idx(i)) reg_sel = base_q[i];
      end
    endcase
  end

  always_comb begin
    rd_next = '0;
    if (hit_data)
      rd_next = cfg_mode_en ? reg_sel : ext_status;
    else if (hit_idx && cfg_mode_en)
      rd_next = idx;
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_next;
  end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [7:0]        DEV_ID     = 8'h3C,
  parameter logic [7:0]        DEV_REV    = 8'h00,
  parameter logic [7:0]        FN_RESET   = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [7:0]        ext_status,
  output logic              fdc_en,
  output logic              sp1_en,
  output logic              sp2_en,
  output logic [1:0]        par_mode,
  output logic [9:0]        fdc_base,
  output logic [9:0]        par_base,
  output logic [9:0]        sp1_base,
  output logic [9:0]        sp2_base
);
  import cfg_regbank_pkg::*;

  localparam int PAD_W = BASE_W - DW;

  logic                            hit_idx;
  logic                            hit_data;
  logic                            data_wr;
  logic [DW-1:0]                   idx_q;
  logic [DW-1:0]                   fn_q;
  logic [NUM_BASE-1:0][DW-1:0]     base_q;
  logic [NUM_BASE-1:0][BASE_W-1:0] base_addr;

  cfg_port_decode #(.ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .cfg_mode_en (cfg_mode_en),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .hit_idx     (hit_idx),
    .hit_data    (hit_data),
    .data_wr     (data_wr),
    .idx_q       (idx_q)
  );

  cfg_reg_store #(.FN_RESET(FN_RESET)) u_store (
    .clk     (clk),
    .rst     (rst),
    .data_wr (data_wr),
    .idx     (idx_q),
    .wdata   (io_wdata),
    .fn_q    (fn_q),
    .base_q  (base_q)
  );

  cfg_read_mux #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_rmux (
    .clk         (clk),
    .rst         (rst),
    .io_rd       (io_rd),
    .cfg_mode_en (cfg_mode_en),
    .hit_idx     (hit_idx),
    .hit_data    (hit_data),
    .idx         (idx_q),
    .fn_q        (fn_q),
    .base_q      (base_q),
    .ext_status  (ext_status),
    .io_rdata    (io_rdata)
  );

  // Every base register holds address bits from bit 2 upward.
  for (genvar g = 0; g < NUM_BASE; g++) begin : g_addr
    assign base_addr[g] = {base_q[g], {PAD_W{1'b0}}};
  end

  assign fdc_en   = fn_q[4];
  assign sp2_en   = fn_q[3];
  assign sp1_en   = fn_q[2];
  assign par_mode = fn_q[1:0];
  assign fdc_base = base_addr[0];
  assign par_base = base_addr[1];
  assign sp1_base = base_addr[2];
  assign sp2_base = base_addr[3];

  logic unused_fn;
  assign unused_fn = ^fn_q[7:5];

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [7:0]        DEV_ID     = 8'h3C
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_mode_en,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [7:0]        ext_status,
  input logic [7:0]        idx_q,
  input logic              fdc_en,
  input logic              sp1_en,
  input logic              sp2_en,
  input logic [1:0]        par_mode,
  input logic [9:0]        fdc_base,
  input logic [9:0]        par_base,
  input logic [9:0]        sp1_base,
  input logic [9:0]        sp2_base
);
  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(INDEX_PORT + 1);

  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (idx_q == 8'h00 && io_rdata == 8'h00 && par_mode == 2'b11 &&
             !fdc_en && !sp1_en && !sp2_en && fdc_base == 10'h0 &&
             par_base == 10'h0 && sp1_base == 10'h0 && sp2_base == 10'h0));

  a_r2_index_capture: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode_en && io_wr && io_addr == INDEX_PORT) |=> idx_q == $past(io_wdata));

  a_r3_locked_no_change: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode_en |=> ($stable(idx_q) && $stable(fdc_en) && $stable(sp1_en) &&
                      $stable(sp2_en) && $stable(par_mode) && $stable(fdc_base) &&
                      $stable(par_base) && $stable(sp1_base) && $stable(sp2_base)));

  a_r3_status_passthru: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !cfg_mode_en && io_addr == DATA_PORT) |=> io_rdata == $past(ext_status));

  a_r4_device_id: assert property (@(posedge clk) disable iff (rst)
    (io_rd && cfg_mode_en && io_addr == DATA_PORT && idx_q == 8'hE0) |=> io_rdata == DEV_ID);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (io_rd && cfg_mode_en && io_addr == DATA_PORT && idx_q == 8'hE2) |=> io_rdata[7:5] == 3'b000);

  a_r8_serial_low_zero: assert property (@(posedge clk) disable iff (rst)
    (sp1_base[2:0] == 3'b000 && sp2_base[2:0] == 3'b000 && fdc_base[3:0] == 4'h0));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

endmodule

bind cfg_regbank cfg_regbank_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst(rst), .cfg_mode_en(cfg_mode_en), .io_addr(io_addr),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .ext_status(ext_status), .idx_q(idx_q), .fdc_en(fdc_en), .sp1_en(sp1_en),
  .sp2_en(sp2_en), .par_mode(par_mode), .fdc_base(fdc_base),
  .par_base(par_base), .sp1_base(sp1_base), .sp2_base(sp2_base)
);

// File: tb/sim_cfg_regbank.sv
module sim_cfg_regbank;

  localparam logic [15:0] IXP = 16'h03F0;
  localparam logic [15:0] DTP = 16'h03F1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_mode_en = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [7:0]  ext_status = 8'h00;
  logic        fdc_en, sp1_en, sp2_en;
  logic [1:0]  par_mode;
  logic [9:0]  fdc_base, par_base, sp1_base, sp2_base;

  always #5 clk = ~clk;

  cfg_regbank u0 (
    .clk(clk), .rst(rst), .cfg_mode_en(cfg_mode_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ext_status(ext_status), .fdc_en(fdc_en), .sp1_en(sp1_en), .sp2_en(sp2_en),
    .par_mode(par_mode), .fdc_base(fdc_base), .par_base(par_base),
    .sp1_base(sp1_base), .sp2_base(sp2_base)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: present one strobe cycle, return at the following falling edge
  task automatic bus(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(a, 1'b1, 1'b0, d);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus(a, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic rdwr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus(a, 1'b1, 1'b1, d);
  endtask

  task automatic setreg(input logic [7:0] ix, input logic [7:0] d);
    wr(IXP, ix); wr(DTP, d);
  endtask

  task automatic chk_defaults(input string tag);
    chk(tag, {29'd0, fdc_en, sp2_en, sp1_en}, 0);
    chk(tag, par_mode, 2'b11);
    chk(tag, {fdc_base, par_base, sp1_base, sp2_base}, 0);
    chk(tag, io_rdata, 8'h00);
  endtask

  // monitor: every sampled read strobe yields one compare a cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (io_rd && !rst) begin
        @(negedge clk);
        if (exp_q.size() > 0) chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", 50000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_defaults("R1 reset defaults");
    cfg_mode_en = 1'b1;
    rd(IXP, 8'h00, "R1 index reset");
    rd(DTP, 8'h00, "R1 index 00 reads zero");

    // R4 fixed identity
    wr(IXP, 8'hE0);
    rd(DTP, 8'h3C, "R4 id");
    wr(DTP, 8'h55);
    rd(DTP, 8'h3C, "R4 id after write");
    setreg(8'hE1, 8'hFF);
    rd(DTP, 8'h00, "R4 revision after write");
    rd(IXP, 8'hE1, "R2 index readback");

    // R5 function select
    setreg(8'hE2, 8'hFF);
    rd(DTP, 8'h1F, "R5 reserved bits clear");
    chk("R5 all on", {fdc_en, sp2_en, sp1_en, par_mode}, 5'b11111);
    setreg(8'hE2, 8'h12);
    chk("R5 fdc only epp", {fdc_en, sp2_en, sp1_en, par_mode}, 5'b10010);
    setreg(8'hE2, 8'h09);
    chk("R5 sp2 ecp", {fdc_en, sp2_en, sp1_en, par_mode}, 5'b01001);
    setreg(8'hE2, 8'h04);
    chk("R5 sp1 uni", {fdc_en, sp2_en, sp1_en, par_mode}, 5'b00100);

    // R6 floppy base
    setreg(8'hE3, 8'hFF);
    rd(DTP, 8'hFC, "R6 low bits forced");
    chk("R6 fdc_base max", fdc_base, 10'h3F0);
    setreg(8'hE3, 8'hA7);
    chk("R6 fdc_base", fdc_base, 10'h290);

    // R7 parallel base
    setreg(8'hE6, 8'hFF);
    chk("R7 par_base max", par_base, 10'h3FC);
    setreg(8'hE6, 8'h5A);
    rd(DTP, 8'h5A, "R7 readback");
    chk("R7 par_base", par_base, 10'h168);

    // R8 serial bases
    setreg(8'hE7, 8'hFF);
    rd(DTP, 8'hFE, "R8 sp1 bit0 forced");
    chk("R8 sp1_base", sp1_base, 10'h3F8);
    setreg(8'hE8, 8'h7F);
    rd(DTP, 8'h7E, "R8 sp2 bit0 forced");
    chk("R8 sp2_base", sp2_base, 10'h1F8);

    // R9 unimplemented indexes
    setreg(8'hE4, 8'hAA);
    rd(DTP, 8'h00, "R9 E4 reads zero");
    setreg(8'hFF, 8'h77);
    rd(DTP, 8'h00, "R9 FF reads zero");
    chk("R9 no side effect", {fdc_base, par_base, sp1_base, sp2_base},
        {10'h290, 10'h168, 10'h3F8, 10'h1F8});
    wr(IXP, 8'hE6);
    rd(DTP, 8'h5A, "R9 E6 untouched");

    // R3 locked mode; the write arrives in the cycle the mode drops
    cfg_mode_en = 1'b0;
    wr(DTP, 8'h00);
    wr(IXP, 8'h10);
    ext_status = 8'hC5;
    rd(DTP, 8'hC5, "R3 status passthru");
    ext_status = 8'h3A;
    rd(DTP, 8'h3A, "R3 status follows");
    rd(IXP, 8'h00, "R3 index port locked");
    chk("R3 par_base kept", par_base, 10'h168);
    cfg_mode_en = 1'b1;
    rd(IXP, 8'hE6, "R10 index kept across mode");
    rd(DTP, 8'h5A, "R3 register kept");

    // R11 read and write in the same cycle
    rdwr(DTP, 8'h33, 8'h5A, "R11 read sees old value");
    rd(DTP, 8'h33, "R11 write took effect");
    chk("R11 par_base", par_base, 10'h0CC);
    repeat (3) @(negedge clk);
    chk("R11 rdata hold", io_rdata, 8'h33);

    // R1 reset again mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_defaults("R1 second reset");
    rd(IXP, 8'h00, "R1 index cleared");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule